// File: doc/BRIEF.md
# Serial-Bus Receive Packet Checker

This block sits behind the physical-layer interface of a serial-bus link and handles every inbound packet before software sees it. Each packet opens with a start strobe that carries a speed code. The code sets how many of the eight data lines hold bits on each cycle. Those bits are packed, most significant first, into 32-bit quadlets. The block then walks the quadlets in order. It checks the transaction code and tests the source node of request packets against one of two node masks. It checks a CRC over the header and a second CRC over the data block of block packets.

Only packets that pass every check become visible at the read port of the internal receive FIFO. Each such packet is stored as its header and data quadlets, without the CRC quadlets, and is followed by a status quadlet. A packet that fails is removed by moving the FIFO write pointer back to where the packet began, so a reader never sees part of one. A bus-reset pulse from the physical layer drops any packet in progress and places a two-quadlet marker packet in the FIFO.

Top module: `rxchk_rx_top`

## Requirements
- R1: Speed codes 0, 1 and 2 make 2, 4 and 8 data lines active. The active lines are the top bits of `phy_data` (bits 7:6, 7:4 or 7:0). Each quadlet is filled most significant bit first.
- R2: A packet whose speed code is greater than 2 is discarded.
- R3: The header CRC uses polynomial 0x04C11DB7, preset to all ones, and runs over whole quadlets, most significant bit first, with no final inversion. Its quadlet is at index 3 for tcode 0 and tcode 2, and at index 4 for tcode 1. The tcode is quadlet 0 bits 7:4. If the received CRC does not match, the packet is discarded.
- R4: For tcode 1, the byte length is quadlet 3 bits 31:16. It is followed by ceil(length/4) data quadlets and then a data CRC quadlet. The data CRC uses the R3 polynomial with a fresh all-ones preset. If it does not match, the packet is discarded.
- R5: Only tcodes 0 (quadlet write request), 1 (block write request) and 2 (write response) are accepted. Any other tcode is discarded.
- R6: For requests (tcode 0 or 1), the source node is quadlet 1 bits 21:16. If quadlet 1 bits 15:0 equal 0xFFFF, bit `node` of `async_node_mask` must be set. Otherwise bit `node` of `phys_node_mask` must be set. If the required bit is clear, the packet is discarded. Responses skip this filter.
- R7: A packet is discarded if its quadlet count does not match what its tcode and length imply, or if bits are left over that do not fill a quadlet at the end strobe.
- R8: An accepted packet is stored as its header quadlets, then its data quadlets, then a status quadlet. The status quadlet has the speed code in bits 10:8, code 0x1 in bits 3:0, and zero in all other bits.
- R9: A bus-reset pulse throws away any packet in progress. It then stores the marker 0x000000E0 followed by the status 0x0000000F.
- R10: Nothing from a discarded packet ever appears at the read port. `rd_empty` stays high if the FIFO held nothing before the packet.
- R11: A packet that does not fit in the FIFO, with its status quadlet, is discarded whole. The bus-reset marker is skipped when fewer than two entries are free.
- R12: After reset the FIFO is empty. A read strobe while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_start | input | 1 | Packet start strobe, a cycle with no data |
| phy_speed | input | 3 | Speed code, sampled with `phy_start` |
| phy_valid | input | 1 | Data lines carry bits this cycle |
| phy_data | input | 8 | Data lines, active lanes at the top |
| phy_end | input | 1 | Packet end strobe, a cycle with no data |
| phy_bus_reset | input | 1 | Bus-reset indication pulse |
| phys_node_mask | input | 64 | Per-node accept mask for physical requests |
| async_node_mask | input | 64 | Per-node accept mask for register-space requests |
| rd_en | input | 1 | Pop the head quadlet |
| rd_data | output | 32 | Head quadlet, shown ahead of the pop |
| rd_empty | output | 1 | No committed quadlet available |

## Verification
A wrong lane count or a packer bit counter that has slipped misaligns every later quadlet. That shows up as a bad header CRC, so the packet is missing from the read port about two cycles after its end strobe. A stale speed or tcode register shows up as a wrong status quadlet or as a discard that should not happen. A filter decode error shows up only for the node numbers near the edges of the masks. A rewind or commit pointer mistake leaves stray quadlets at the read port, or lets a discarded packet appear there. The bench catches both by checking that the FIFO is empty after each discarded packet and after the last quadlet of each accepted one.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam int QW = 32;
  localparam logic [QW-1:0] CRC_POLY = 32'h04C1_1DB7;

  localparam logic [3:0] TC_QWR  = 4'h0;
  localparam logic [3:0] TC_BWR  = 4'h1;
  localparam logic [3:0] TC_WRSP = 4'h2;
  localparam logic [3:0] TC_MARK = 4'hE;

  localparam logic [3:0] CODE_OK = 4'h1;
  localparam logic [3:0] CODE_BR = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_BR_HDR,
    ST_BR_ST
  } rx_state_e;

  // One quadlet through the CRC shift register, MSB first.
  function automatic logic [QW-1:0] crc_quad(input logic [QW-1:0] c,
                                             input logic [QW-1:0] d);
    logic [QW-1:0] r;
    r = c;
    for (int i = QW - 1; i >= 0; i--) begin
      if (r[QW-1] ^ d[i]) r = {r[QW-2:0], 1'b0} ^ CRC_POLY;
      else                r = {r[QW-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rxchk_lane_packer.sv
module rxchk_lane_packer #(
  parameter int LANE_MAX = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [2:0]              speed_i,
  input  logic                    valid_i,
  input  logic [LANE_MAX-1:0]     data_i,
  input  logic                    end_i,
  output logic                    q_valid_o,
  output logic [rxchk_pkg::QW-1:0] q_data_o,
  output logic                    end_o,
  output logic                    partial_o
);
  localparam int QW    = rxchk_pkg::QW;
  localparam int CW    = $clog2(QW) + 1;
  localparam int L_LO  = LANE_MAX / 4;
  localparam int L_MID = LANE_MAX / 2;

  logic [2:0]    spd_q, spd_n;
  logic [QW-1:0] sr_q, sr_n, sr_sh;
  logic [CW-1:0] cnt_q, cnt_n, step, cnt_sum;
  logic          qv_q, qv_n;
  logic [QW-1:0] qd_q, qd_n;
  logic          end_q, end_n;
  logic          part_q, part_n;

  // Lane selection per speed code
  always_comb begin
    case (spd_q)
      3'd0: begin
        sr_sh = {sr_q[QW-L_LO-1:0], data_i[LANE_MAX-1 -: L_LO]};
        step  = CW'(L_LO);
      end
      3'd1: begin
        sr_sh = {sr_q[QW-L_MID-1:0], data_i[LANE_MAX-1 -: L_MID]};
        step  = CW'(L_MID);
      end
      default: begin
        sr_sh = {sr_q[QW-LANE_MAX-1:0], data_i};
        step  = CW'(LANE_MAX);
      end
    endcase
    cnt_sum = cnt_q + step;
  end

  always_comb begin
    spd_n  = spd_q;
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    qv_n   = 1'b0;
    qd_n   = qd_q;
    end_n  = 1'b0;
    part_n = part_q;
    if (start_i) begin
      spd_n = speed_i;
      cnt_n = '0;
    end else if (valid_i) begin
      sr_n = sr_sh;
      if (cnt_sum == CW'(QW)) begin
        qv_n  = 1'b1;
        qd_n  = sr_sh;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_sum;
      end
    end else if (end_i) begin
      end_n  = 1'b1;
      part_n = (cnt_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q  <= '0;
      sr_q   <= '0;
      cnt_q  <= '0;
      qv_q   <= 1'b0;
      qd_q   <= '0;
      end_q  <= 1'b0;
      part_q <= 1'b0;
    end else begin
      spd_q  <= spd_n;
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      qv_q   <= qv_n;
      qd_q   <= qd_n;
      end_q  <= end_n;
      part_q <= part_n;
    end
  end

  assign q_valid_o = qv_q;
  assign q_data_o  = qd_q;
  assign end_o     = end_q;
  assign partial_o = part_q;
endmodule

// File: rtl/rxchk_crc32.sv
module rxchk_crc32 (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     preset_i,
  input  logic                     upd_i,
  input  logic [rxchk_pkg::QW-1:0] din_i,
  output logic [rxchk_pkg::QW-1:0] crc_o
);
  localparam int QW = rxchk_pkg::QW;

  logic [QW-1:0] crc_q, crc_n;
  logic          crc_en;

  always_comb begin
    crc_en = preset_i | upd_i;
    if (preset_i) crc_n = '1;
    else          crc_n = rxchk_pkg::crc_quad(crc_q, din_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (crc_en) crc_q <= crc_n;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rxchk_pkt_fifo.sv
module rxchk_pkt_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic                     commit_i,
  input  logic                     rewind_i,
  input  logic                     rd_en_i,
  output logic [DW-1:0]            rd_data_o,
  output logic                     rd_empty_o,
  output logic                     full_o,
  output logic [$clog2(DEPTH):0]   free_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_n;
  logic [PW-1:0] cm_ptr_q, cm_ptr_n;
  logic [PW-1:0] rd_ptr_q, rd_ptr_n;
  logic [PW-1:0] used;
  logic          wr_do, rd_do, empty;

  always_comb begin
    used     = wr_ptr_q - rd_ptr_q;
    full_o   = (used == PW'(DEPTH));
    free_o   = PW'(DEPTH) - used;
    empty    = (cm_ptr_q == rd_ptr_q);
    wr_do    = wr_en_i & ~full_o & ~rewind_i;
    rd_do    = rd_en_i & ~empty;
    wr_ptr_n = wr_ptr_q;
    cm_ptr_n = cm_ptr_q;
    rd_ptr_n = rd_ptr_q;
    if (rewind_i)   wr_ptr_n = cm_ptr_q;
    else if (wr_do) wr_ptr_n = wr_ptr_q + 1'b1;
    if (commit_i)   cm_ptr_n = wr_ptr_n;
    if (rd_do)      rd_ptr_n = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cm_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      cm_ptr_q <= cm_ptr_n;
      rd_ptr_q <= rd_ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_do) mem_q[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o  = mem_q[rd_ptr_q[AW-1:0]];
  assign rd_empty_o = empty;
endmodule

// File: rtl/rxchk_rx_top.sv
module rxchk_rx_top #(
  parameter int LANE_MAX   = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int NODE_BITS  = 6,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    phy_start,
  input  logic [2:0]              phy_speed,
  input  logic                    phy_valid,
  input  logic [LANE_MAX-1:0]     phy_data,
  input  logic                    phy_end,
  input  logic                    phy_bus_reset,
  input  logic [2**NODE_BITS-1:0] phys_node_mask,
  input  logic [2**NODE_BITS-1:0] async_node_mask,
  input  logic                    rd_en,
  output logic [31:0]             rd_data,
  output logic                    rd_empty
);
  import rxchk_pkg::*;

  localparam int FREE_W = $clog2(FIFO_DEPTH) + 1;
  localparam logic [2:0] SPD_MAX = 3'd2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  logic          pk_valid, pk_end, pk_partial;
  logic [QW-1:0] pk_q;
  logic          crc_preset, crc_upd;
  logic [QW-1:0] crc_val;
  logic          fifo_wr, fifo_commit, fifo_rewind, fifo_full;
  logic [QW-1:0] fifo_wdata;
  logic [FREE_W-1:0] fifo_free;

  rxchk_lane_packer #(.LANE_MAX(LANE_MAX)) u_pack (
    .clk(clk), .rst_n(rst_l),
    .start_i(phy_start), .speed_i(phy_speed),
    .valid_i(phy_valid), .data_i(phy_data), .end_i(phy_end),
    .q_valid_o(pk_valid), .q_data_o(pk_q),
    .end_o(pk_end), .partial_o(pk_partial)
  );

  rxchk_crc32 u_crc (
    .clk(clk), .rst_n(rst_l),
    .preset_i(crc_preset), .upd_i(crc_upd),
    .din_i(pk_q), .crc_o(crc_val)
  );

  rxchk_pkt_fifo #(.DW(QW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_l),
    .wr_en_i(fifo_wr), .wr_data_i(fifo_wdata),
    .commit_i(fifo_commit), .rewind_i(fifo_rewind),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_empty_o(rd_empty),
    .full_o(fifo_full), .free_o(fifo_free)
  );

  rx_state_e      state_q, state_n;
  logic [LEN_W-1:0] idx_q, idx_n;
  logic [3:0]     tc_q, tc_n;
  logic [2:0]     spd_q, spd_n;
  logic           bad_q, bad_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic           brgo_q, brgo_n;

  logic             is_block, is_req, tc_known, filt_pass;
  logic [LEN_W-1:0] hcrc_idx, dq_cnt, dcrc_idx, pkt_total;
  logic [NODE_BITS-1:0] src_node;
  logic             in_payload, at_crc;

  // Packet geometry derived from the decoded header
  always_comb begin
    is_block  = (tc_q == TC_BWR);
    is_req    = (tc_q == TC_QWR) || (tc_q == TC_BWR);
    tc_known  = (pk_q[7:4] == TC_QWR) || (pk_q[7:4] == TC_BWR) ||
                (pk_q[7:4] == TC_WRSP);
    src_node  = pk_q[16 +: NODE_BITS];
    filt_pass = (pk_q[15:0] == 16'hFFFF) ? async_node_mask[src_node]
                                         : phys_node_mask[src_node];
    hcrc_idx  = is_block ? LEN_W'(4) : LEN_W'(3);
    dq_cnt    = {2'b00, len_q[LEN_W-1:2]} + LEN_W'(|len_q[1:0]);
    dcrc_idx  = LEN_W'(5) + dq_cnt;
    pkt_total = is_block ? (dcrc_idx + LEN_W'(1)) : LEN_W'(4);
    in_payload = (idx_q < hcrc_idx) ||
                 (is_block && (idx_q > hcrc_idx) && (idx_q < dcrc_idx));
    at_crc     = (idx_q == hcrc_idx) || (is_block && (idx_q == dcrc_idx));
  end

  always_comb begin
    state_n     = state_q;
    idx_n       = idx_q;
    tc_n        = tc_q;
    spd_n       = spd_q;
    bad_n       = bad_q;
    len_n       = len_q;
    brgo_n      = brgo_q;
    fifo_wr     = 1'b0;
    fifo_wdata  = pk_q;
    fifo_commit = 1'b0;
    fifo_rewind = 1'b0;
    crc_preset  = 1'b0;
    crc_upd     = 1'b0;
    if (phy_bus_reset) begin
      fifo_rewind = 1'b1;
      crc_preset  = 1'b1;
      state_n     = ST_BR_HDR;
    end else if (phy_start && (state_q == ST_IDLE || state_q == ST_RECV)) begin
      fifo_rewind = 1'b1;
      crc_preset  = 1'b1;
      idx_n       = '0;
      tc_n        = '0;
      len_n       = '0;
      spd_n       = phy_speed;
      bad_n       = (phy_speed > SPD_MAX);
      state_n     = ST_RECV;
    end else begin
      case (state_q)
        ST_RECV: begin
          if (pk_valid) begin
            if (idx_q != '1) idx_n = idx_q + 1'b1;
            if (idx_q == '0) begin
              tc_n = pk_q[7:4];
              if (!tc_known) bad_n = 1'b1;
            end
            if (idx_q == LEN_W'(1) && is_req && !filt_pass) bad_n = 1'b1;
            if (idx_q == LEN_W'(3) && is_block) len_n = pk_q[31:16];
            if (in_payload) begin
              crc_upd = 1'b1;
              if (fifo_full) bad_n = 1'b1;
              else           fifo_wr = 1'b1;
            end else if (at_crc) begin
              crc_preset = 1'b1;
              if (crc_val != pk_q) bad_n = 1'b1;
            end else begin
              bad_n = 1'b1;
            end
          end else if (pk_end) begin
            state_n = ST_IDLE;
            if (!bad_q && !pk_partial && idx_q == pkt_total && !fifo_full) begin
              fifo_wr     = 1'b1;
              fifo_wdata  = {21'b0, spd_q, 4'b0, CODE_OK};
              fifo_commit = 1'b1;
            end else begin
              fifo_rewind = 1'b1;
            end
          end
        end
        ST_BR_HDR: begin
          state_n = ST_BR_ST;
          brgo_n  = (fifo_free >= FREE_W'(2));
          if (fifo_free >= FREE_W'(2)) begin
            fifo_wr    = 1'b1;
            fifo_wdata = {24'b0, TC_MARK, 4'b0};
          end
        end
        ST_BR_ST: begin
          state_n = ST_IDLE;
          if (brgo_q) begin
            fifo_wr     = 1'b1;
            fifo_wdata  = {28'b0, CODE_BR};
            fifo_commit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tc_q    <= '0;
      spd_q   <= '0;
      bad_q   <= 1'b0;
      len_q   <= '0;
      brgo_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      tc_q    <= tc_n;
      spd_q   <= spd_n;
      bad_q   <= bad_n;
      len_q   <= len_n;
      brgo_q  <= brgo_n;
    end
  end
endmodule

// File: rtl/rxchk_rx_sva.sv
module rxchk_rx_sva #(
  parameter int FW    = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phy_bus_reset,
  input logic          fifo_wr,
  input logic          fifo_commit,
  input logic          fifo_rewind,
  input logic [31:0]   fifo_wdata,
  input logic [FW-1:0] fifo_free
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_free != '0)); // R11
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_free <= FW'(DEPTH)); // R11
  AST_COMMIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_commit |-> (fifo_wr && (fifo_wdata[3:0] == 4'h1 || fifo_wdata[3:0] == 4'hF))); // R8
  AST_BR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    phy_bus_reset |-> (fifo_rewind && !fifo_commit)); // R9
  AST_BR_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    phy_bus_reset |=> !fifo_commit); // R9
endmodule

bind rxchk_rx_top rxchk_rx_sva #(.FW(FREE_W), .DEPTH(FIFO_DEPTH)) sva_i (
  .clk(clk),
  .rst_n(rst_n),
  .phy_bus_reset(phy_bus_reset),
  .fifo_wr(fifo_wr),
  .fifo_commit(fifo_commit),
  .fifo_rewind(fifo_rewind),
  .fifo_wdata(fifo_wdata),
  .fifo_free(fifo_free)
);

// File: tb/rxchk_rx_top_tb.sv
module rxchk_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  tc;
    logic [2:0]  spd;
    logic [5:0]  src;
    logic [15:0] offhi;
    logic [15:0] len;
    logic        bh;
    logic        bd;
    logic        tr;
    logic        ok;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 3'd0, 6'd5,  16'h0001, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 R3 R6 R8 phys pass
    '{4'h0, 3'd1, 6'd9,  16'hFFFF, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 R6 async pass
    '{4'h0, 3'd2, 6'd9,  16'h0001, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 phys fail
    '{4'h1, 3'd2, 6'd4,  16'h0000, 16'd8, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 block
    '{4'h1, 3'd1, 6'd6,  16'h0000, 16'd5, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 rounded length
    '{4'h1, 3'd2, 6'd4,  16'h0000, 16'd8, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 data CRC bad
    '{4'h0, 3'd2, 6'd4,  16'h0000, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 header CRC bad
    '{4'h2, 3'd0, 6'd60, 16'h0001, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 response bypass
    '{4'h5, 3'd2, 6'd4,  16'h0000, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 unknown tcode
    '{4'h0, 3'd3, 6'd4,  16'h0000, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 bad speed
    '{4'h1, 3'd0, 6'd5,  16'h0000, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 zero length
    '{4'h0, 3'd2, 6'd4,  16'h0000, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 leftover bits
    '{4'h1, 3'd2, 6'd7,  16'hFFFF, 16'd4, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 async fail
  };

  logic        clk, rst_n;
  logic        phy_start, phy_valid, phy_end, phy_bus_reset;
  logic [2:0]  phy_speed;
  logic [7:0]  phy_data;
  logic [63:0] phys_node_mask, async_node_mask;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        rd_empty;

  int errors = 0;
  int checks = 0;
  logic [31:0] pq [0:31];
  int          npq;
  logic [31:0] exq [0:31];
  int          nex;

  rxchk_rx_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .phy_start(phy_start), .phy_speed(phy_speed),
    .phy_valid(phy_valid), .phy_data(phy_data), .phy_end(phy_end),
    .phy_bus_reset(phy_bus_reset),
    .phys_node_mask(phys_node_mask), .async_node_mask(async_node_mask),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] s;
    s = c;
    for (int b = 31; b >= 0; b--) begin
      logic fb;
      fb = s[31] ^ d[b];
      s  = s << 1;
      if (fb) s = s ^ 32'h04C11DB7;
    end
    return s;
  endfunction

  task automatic chk(input logic cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Build wire quadlets and the quadlets expected in the FIFO
  task automatic build(input vec_t v, input int tag);
    logic [31:0] c;
    int hdr, dq;
    pq[0] = {16'hFFC0, 6'd3, 2'b01, v.tc, 4'h0};
    pq[1] = {10'h3FF, v.src, v.offhi};
    pq[2] = 32'hA5A5_0000 | 32'(tag);
    hdr = 3;
    if (v.tc == 4'h1) begin
      pq[3] = {v.len, 16'h0000};
      hdr = 4;
    end
    c = '1;
    for (int k = 0; k < hdr; k++) begin
      c = ref_crc(c, pq[k]);
      exq[k] = pq[k];
    end
    pq[hdr] = c ^ {31'b0, v.bh};
    npq = hdr + 1;
    nex = hdr;
    if (v.tc == 4'h1) begin
      dq = (int'(v.len) + 3) / 4;
      c = '1;
      for (int j = 0; j < dq; j++) begin
        pq[npq + j] = (32'h0102_0304 * 32'(j + 1)) ^ 32'(tag << 8);
        c = ref_crc(c, pq[npq + j]);
        exq[nex + j] = pq[npq + j];
      end
      pq[npq + dq] = c ^ {31'b0, v.bd};
      npq = npq + dq + 1;
      nex = nex + dq;
    end
    exq[nex] = {21'b0, v.spd, 4'b0, 4'h1};
    nex = nex + 1;
  endtask

  // Drive npq quadlets (or cut of them, without end strobe)
  task automatic send(input logic [2:0] spd, input logic trunc, input int cut);
    int w, nq;
    w  = (spd == 3'd0) ? 2 : (spd == 3'd1) ? 4 : 8;
    nq = (cut >= 0) ? cut : npq;
    @(negedge clk);
    phy_start = 1'b1;
    phy_speed = spd;
    @(negedge clk);
    phy_start = 1'b0;
    for (int k = 0; k < nq; k++) begin
      for (int b = 32 - w; b >= 0; b -= w) begin
        logic [31:0] sh;
        if (!(trunc && k == nq - 1 && b == 0)) begin
          sh = pq[k] >> b;
          phy_valid = 1'b1;
          phy_data  = 8'(sh << (8 - w));
          @(negedge clk);
        end
      end
    end
    phy_valid = 1'b0;
    phy_data  = '0;
    if (cut < 0) begin
      phy_end = 1'b1;
      @(negedge clk);
      phy_end = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic pop(output logic [31:0] v, input string req);
    @(negedge clk);
    chk(!rd_empty, req, {31'b0, rd_empty}, 32'h0);
    v = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_stored(input int n, input string req);
    logic [31:0] v;
    for (int k = 0; k < n; k++) begin
      pop(v, req);
      chk(v == exq[k], req, v, exq[k]);
    end
    chk(rd_empty === 1'b1, req, {31'b0, rd_empty}, 32'h1);
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk);
    phy_bus_reset = 1'b1;
    @(negedge clk);
    phy_bus_reset = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    phy_start = 1'b0; phy_speed = '0; phy_valid = 1'b0; phy_data = '0;
    phy_end = 1'b0; phy_bus_reset = 1'b0; rd_en = 1'b0;
    phys_node_mask  = 64'h0000_0000_0000_00F0;
    async_node_mask = 64'h0000_0000_0000_0F00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: empty after reset, pop on empty ignored
    chk(rd_empty === 1'b1, "R12 empty after reset", {31'b0, rd_empty}, 32'h1);
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(rd_empty === 1'b1, "R12 pop on empty", {31'b0, rd_empty}, 32'h1);

    // Table walk: accepted packets R8, rejected ones R10
    for (int i = 0; i < NV; i++) begin
      build(VECS[i], i);
      send(VECS[i].spd, VECS[i].tr, -1);
      if (VECS[i].ok) expect_stored(nex, $sformatf("R8 vector %0d", i));
      else chk(rd_empty === 1'b1, $sformatf("R10 vector %0d discarded", i),
               {31'b0, rd_empty}, 32'h1);
    end

    // R9: marker packet on bus reset
    pulse_bus_reset();
    exq[0] = 32'h0000_00E0;
    exq[1] = 32'h0000_000F;
    expect_stored(2, "R9 marker");

    // R9: bus reset mid-packet leaves only the marker
    build(VECS[3], 40);
    send(3'd2, 1'b0, 3);
    pulse_bus_reset();
    exq[0] = 32'h0000_00E0;
    exq[1] = 32'h0000_000F;
    expect_stored(2, "R9 abort in flight");

    // R11: packet larger than the FIFO is dropped whole
    build('{4'h1, 3'd2, 6'd4, 16'h0000, 16'd64, 1'b0, 1'b0, 1'b0, 1'b1}, 50);
    send(3'd2, 1'b0, -1);
    chk(rd_empty === 1'b1, "R11 oversize dropped", {31'b0, rd_empty}, 32'h1);

    // R11: FIFO nearly full, marker skipped; stored packet intact
    build('{4'h1, 3'd2, 6'd4, 16'h0000, 16'd40, 1'b0, 1'b0, 1'b0, 1'b1}, 51);
    send(3'd2, 1'b0, -1);
    pulse_bus_reset();
    expect_stored(nex, "R11 marker skipped when full");

    // R1 again after corner cases: 2-line packet still assembles correctly
    build(VECS[0], 60);
    send(3'd0, 1'b0, -1);
    expect_stored(nex, "R1 two-lane after recovery");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule